// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog built on a free-running timebase counter. A timeout window closes every 2^N clock cycles. When the watchdog is armed, the first window closure sets a "bark" flag and raises a level interrupt. If software has not cleared that flag by the next closure, the block "bites". A bite drives a reset pulse of fixed length and latches a sticky reset-cause flag. The worst-case time from the last service to reset is therefore two windows.

Arming needs two keys in two different registers, and the watchdog stops as soon as either key drops. Software services the watchdog by writing ones to the status bits, which clears them. Writing zeros to them does nothing. An optional build-time lock stops the keys from being removed once the watchdog has been armed. The timebase count can be read at any time, so software can confirm that the timer is running.

The bus is a simple 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `twostage_wdt`

## Requirements
- R1: Registers are selected by byte address bits [3:2], and all higher address bits must be zero. Offset 0x0 is control 0: bit 3 is the reset-cause flag, bit 2 is the bark flag, bit 1 is key A, and all other bits read 0. Offset 0x4 is control 1: bit 0 is key B. Offset 0x8 returns the timebase count. Every other offset reads 0.
- R2: The timebase count resets to 0 and increases by one on every clock, whether or not the watchdog is armed. It wraps at its maximum value.
- R3: A window closes in every cycle in which the low N bits of the count are all ones, which is once every 2^N cycles.
- R4: If the watchdog is armed and the bark flag is clear when a window closes, the bark flag is set on that edge. No reset pulse is produced.
- R5: If the watchdog is armed and the bark flag is still set when a window closes, that edge is a bite. A bite sets the reset-cause flag and starts the reset pulse.
- R6: A write to offset 0x0 with bit 2 or bit 3 set clears the matching flag, and a 0 in those bit positions has no effect. A clear of the bark flag on the same edge as a window closure counts as a service: there is no bite, and the bark flag is set again.
- R7: The watchdog is armed only while both key A and key B are 1. While it is disarmed, window closures change no flag.
- R8: When the lock option is built in, writes cannot clear either key once both keys have been 1 at the same time. Until then, the keys can be written freely.
- R9: The reset output is high for exactly RST_PULSE_LEN cycles, starting on the cycle after the bite. The reset-cause flag stays set after the pulse ends, until it is cleared by a write or by power-on reset.
- R10: The interrupt output is high exactly while the bark flag is set.
- R11: After power-on reset, the keys, both flags, the interrupt and the reset output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Bark interrupt, level high |
| wdt_reset_o | output | 1 | Bite reset pulse, active high |

## Verification
The bench builds the block with INTERVAL_LOG2 = 4 and RST_PULSE_LEN = 3. With a 16-cycle window, many bark, service and bite sequences fit in a short run. A 3-cycle pulse makes an off-by-one in its length easy to see. The bench locks onto the window phase by polling the timebase register, so it can place a service write exactly on a closing edge. A second instance is built with ENABLE_ONCE = 1, so the key lock can be tested both before and after the first arming.

// File: rtl/twdt_pkg.sv
package twdt_pkg;
  // Bit positions in the two control words (software-visible layout)
  localparam int unsigned CTL0_CAUSE_BIT = 3;
  localparam int unsigned CTL0_BARK_BIT  = 2;
  localparam int unsigned CTL0_KEYA_BIT  = 1;
  localparam int unsigned CTL1_KEYB_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_CTL0  = 2'd0,
    SEL_CTL1  = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Word select from byte address bits [3:2]
  function automatic reg_sel_e word_select(input logic [1:0] word);
    return reg_sel_e'(word);
  endfunction

  // Bark flag after one edge: closure while armed sets it, otherwise a clear wins
  function automatic logic bark_next(input logic bark, input logic clr, input logic tick);
    return tick | (bark & ~clr);
  endfunction

  // Cause flag after one edge: a bite sets it, a clear drops it
  function automatic logic cause_next(input logic cause, input logic clr, input logic bite);
    return bite | (cause & ~clr);
  endfunction
endpackage

// File: rtl/twdt_timebase.sv
module twdt_timebase #(
  parameter int unsigned TB_W          = 32,
  parameter int unsigned INTERVAL_LOG2 = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TB_W-1:0] count_o,
  output logic            expire_o
);
  localparam logic [TB_W-1:0] LOW_MASK =
    TB_W'((64'd1 << INTERVAL_LOG2) - 64'd1);

  logic [TB_W-1:0] count_q;

  function automatic logic at_window_end(input logic [TB_W-1:0] c);
    return (c & LOW_MASK) == LOW_MASK;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + TB_W'(1);
  end

  assign count_o  = count_q;
  assign expire_o = at_window_end(count_q);

  // R2: free-running step of one per clock
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count_q == $past(count_q) + TB_W'(1));

  // R3: a closure is a single-cycle event
  a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/twdt_core.sv
module twdt_core
  import twdt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter bit          ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_i,
  input  logic              wr_ctl0_i,
  input  logic              wr_ctl1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              keya_o,
  output logic              keyb_o,
  output logic              bark_o,
  output logic              cause_o,
  output logic              bite_o
);
  logic keya_q, keyb_q, bark_q, cause_q, lock_q;
  logic armed, lock_eff, tick, clr_bark, clr_cause, bark_eff;

  assign armed     = keya_q & keyb_q;
  assign lock_eff  = lock_q | (ENABLE_ONCE & armed);
  assign tick      = expire_i & armed;
  assign clr_bark  = wr_ctl0_i & wdata_i[CTL0_BARK_BIT];
  assign clr_cause = wr_ctl0_i & wdata_i[CTL0_CAUSE_BIT];
  assign bark_eff  = bark_q & ~clr_bark;
  assign bite_o    = tick & bark_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keya_q  <= 1'b0;
      keyb_q  <= 1'b0;
      bark_q  <= 1'b0;
      cause_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_ctl0_i) keya_q <= wdata_i[CTL0_KEYA_BIT] | lock_eff;
      if (wr_ctl1_i) keyb_q <= wdata_i[CTL1_KEYB_BIT] | lock_eff;
      bark_q  <= bark_next(bark_q, clr_bark, tick);
      cause_q <= cause_next(cause_q, clr_cause, bite_o);
      lock_q  <= lock_eff;
    end
  end

  assign keya_o  = keya_q;
  assign keyb_o  = keyb_q;
  assign bark_o  = bark_q;
  assign cause_o = cause_q;

  // R4: the bark flag only rises on an armed closure
  a_r4_bark_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_q) |-> $past(expire_i && keya_q && keyb_q));

  // R7: disarmed closures leave the bark flag alone
  a_r7_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!keya_q || !keyb_q) |=> !$rose(bark_q));

  // R6: the bark flag only drops through a write of one
  a_r6_bark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_q && !(wr_ctl0_i && wdata_i[CTL0_BARK_BIT])) |=> bark_q);

  // R5: a bite latches the cause flag
  a_r5_bite_latches: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |=> cause_q);

  // R9: the cause flag survives until cleared
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !(wr_ctl0_i && wdata_i[CTL0_CAUSE_BIT])) |=> cause_q);

  generate
    if (ENABLE_ONCE) begin : g_lock_check
      // R8: once armed, armed for good
      a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (keya_q && keyb_q) |=> (keya_q && keyb_q));
    end
  endgenerate
endmodule

// File: rtl/twdt_pulse.sv
module twdt_pulse #(
  parameter int unsigned RST_PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bite_i,
  output logic rst_o
);
  localparam int unsigned PW = $clog2(RST_PULSE_LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(RST_PULSE_LEN);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (bite_i)         left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign rst_o = (left_q != '0);

  // R9: a pulse is only ever started by a bite
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(bite_i));

  // R9: remaining length never exceeds the configured length
  a_r9_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= LOAD);
endmodule

// File: rtl/twdt_regif.sv
module twdt_regif
  import twdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TB_W   = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic              keya_i,
  input  logic              keyb_i,
  input  logic              bark_i,
  input  logic              cause_i,
  input  logic [TB_W-1:0]   count_i,
  output logic              wr_ctl0_o,
  output logic              wr_ctl1_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic     upper_zero;
  reg_sel_e sel;

  assign upper_zero = ((addr_i >> 4) == '0);
  assign sel        = upper_zero ? word_select(addr_i[3:2]) : SEL_NONE;
  assign wr_ctl0_o  = wen_i & (sel == SEL_CTL0);
  assign wr_ctl1_o  = wen_i & (sel == SEL_CTL1);

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTL0: begin
        rdata_o[CTL0_CAUSE_BIT] = cause_i;
        rdata_o[CTL0_BARK_BIT]  = bark_i;
        rdata_o[CTL0_KEYA_BIT]  = keya_i;
      end
      SEL_CTL1:  rdata_o[CTL1_KEYB_BIT] = keyb_i;
      SEL_TBASE: rdata_o = DATA_W'(count_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned TB_W          = 32,
  parameter int unsigned INTERVAL_LOG2 = 16,
  parameter int unsigned RST_PULSE_LEN = 4,
  parameter bit          ENABLE_ONCE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdt_reset_o
);
  logic [TB_W-1:0] count;
  logic expire, wr_ctl0, wr_ctl1;
  logic keya, keyb, bark, cause, bite;

  twdt_timebase #(.TB_W(TB_W), .INTERVAL_LOG2(INTERVAL_LOG2)) u_tb (
    .clk(clk), .rst_n(rst_n), .count_o(count), .expire_o(expire));

  twdt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W)) u_regs (
    .addr_i(bus_addr), .wen_i(bus_wen), .keya_i(keya), .keyb_i(keyb),
    .bark_i(bark), .cause_i(cause), .count_i(count),
    .wr_ctl0_o(wr_ctl0), .wr_ctl1_o(wr_ctl1), .rdata_o(bus_rdata));

  twdt_core #(.DATA_W(DATA_W), .ENABLE_ONCE(ENABLE_ONCE)) u_core (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .wr_ctl0_i(wr_ctl0),
    .wr_ctl1_i(wr_ctl1), .wdata_i(bus_wdata), .keya_o(keya), .keyb_o(keyb),
    .bark_o(bark), .cause_o(cause), .bite_o(bite));

  twdt_pulse #(.RST_PULSE_LEN(RST_PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .bite_i(bite), .rst_o(wdt_reset_o));

  assign irq_o = bark;

  // R10: interrupt rises only together with a closure the cycle before
  a_r10_irq_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(expire));
endmodule

// File: tb/twostage_wdt_test.sv
module twostage_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 4;
  localparam int PLEN = 3;

  // kind: 0 write, 1 read-check, 2 sync to timebase phase (data), 3 step (data cycles)
  localparam int NV = 30;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 4'h0, 32'h2, 32'h0},   // R1 key A
    {2'd1, 4'h0, 32'h0, 32'h2},
    {2'd0, 4'h4, 32'h1, 32'h0},   // R1 key B
    {2'd1, 4'h4, 32'h0, 32'h1},
    {2'd2, 4'h8, 32'hF, 32'h0},
    {2'd3, 4'h0, 32'h1, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h6},   // R4 bark
    {2'd0, 4'h0, 32'h6, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h2},   // R6 clear
    {2'd2, 4'h8, 32'hF, 32'h0},
    {2'd3, 4'h0, 32'h1, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h6},
    {2'd2, 4'h8, 32'hF, 32'h0},
    {2'd0, 4'h0, 32'h6, 32'h0},   // R6 clear on closing edge
    {2'd1, 4'h0, 32'h0, 32'h6},
    {2'd2, 4'h8, 32'hF, 32'h0},
    {2'd3, 4'h0, 32'h1, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'hE},   // R5 bite
    {2'd0, 4'h0, 32'h2, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'hE},   // R6 zeros ignored
    {2'd0, 4'h0, 32'hE, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h2},
    {2'd0, 4'h4, 32'h0, 32'h0},
    {2'd1, 4'h4, 32'h0, 32'h0},
    {2'd2, 4'h8, 32'hF, 32'h0},
    {2'd3, 4'h0, 32'h1, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h2},   // R7 disarmed
    {2'd1, 4'hC, 32'h0, 32'h0},   // R1 unused offset
    {2'd0, 4'h0, 32'h0, 32'h0},
    {2'd1, 4'h0, 32'h0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wen_a = 1'b0, wen_b = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic irq_a, irq_b, wrst_a, wrst_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdt #(.INTERVAL_LOG2(NLOG), .RST_PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen_a),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_o(irq_a), .wdt_reset_o(wrst_a));

  twostage_wdt #(.INTERVAL_LOG2(NLOG), .RST_PULSE_LEN(PLEN), .ENABLE_ONCE(1'b1)) uut_lock (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen_b),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_o(irq_b), .wdt_reset_o(wrst_b));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit to_b, input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (to_b) wen_b = 1'b1; else wen_a = 1'b1;
    @(negedge clk);
    wen_a = 1'b0; wen_b = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] va, output logic [31:0] vb);
    addr = a;
    #1;
    va = rdata_a; vb = rdata_b;
  endtask

  task automatic sync_phase(input logic [3:0] ph);
    logic [31:0] va, vb;
    for (int k = 0; k < 64; k++) begin
      rd(4'h8, va, vb);
      if (va[3:0] == ph) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] va, vb, c0;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(4'h0, va, vb);
    check(va == 0 && vb == 0, "R11 ctl0", va, 0);
    rd(4'h4, va, vb);
    check(va == 0 && vb == 0, "R11 ctl1", va, 0);
    check({irq_a, wrst_a, irq_b, wrst_b} == 4'b0, "R11 outputs",
          {28'b0, irq_a, wrst_a, irq_b, wrst_b}, 0);

    // R2 timebase advances by one per clock
    rd(4'h8, c0, vb);
    repeat (5) @(negedge clk);
    rd(4'h8, va, vb);
    check(va - c0 == 5, "R2 step", va - c0, 5);

    // table walk on the unlocked instance
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [3:0] a;
      logic [31:0] d, e;
      {kind, a, d, e} = VEC[i];
      case (kind)
        2'd0: wr(1'b0, a, d);
        2'd1: begin
          rd(a, va, vb);
          check(va == e, $sformatf("R1/R4-R7 vector %0d", i), va, e);
        end
        2'd2: sync_phase(d[3:0]);
        default: repeat (d) @(negedge clk);
      endcase
    end

    // R3 closure sets bark exactly when low bits were all ones
    wr(1'b0, 4'h4, 32'h1);
    wr(1'b0, 4'h0, 32'h2);
    sync_phase(4'hE);
    @(negedge clk);
    rd(4'h0, va, vb);
    check(va == 32'h2, "R3 not before closure", va, 32'h2);
    @(negedge clk);
    rd(4'h0, va, vb);
    check(va == 32'h6, "R3 closure", va, 32'h6);
    check(irq_a == 1'b1, "R10 irq with bark", {31'b0, irq_a}, 1);

    // R9 pulse length and sticky cause
    sync_phase(4'hF);
    check(wrst_a == 1'b0, "R9 before bite", {31'b0, wrst_a}, 0);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (wrst_a) highs++;
    end
    check(highs == PLEN, "R9 pulse length", highs, PLEN);
    rd(4'h0, va, vb);
    check(va == 32'hE, "R9 cause sticky", va, 32'hE);
    wr(1'b0, 4'h0, 32'hE);
    check(irq_a == 1'b0, "R10 irq cleared", {31'b0, irq_a}, 0);

    // R8 lock instance: free before arming
    wr(1'b1, 4'h0, 32'h2);
    wr(1'b1, 4'h0, 32'h0);
    rd(4'h0, va, vb);
    check(vb == 32'h0, "R8 unlocked before arming", vb, 0);
    wr(1'b1, 4'h0, 32'h2);
    wr(1'b1, 4'h4, 32'h1);
    wr(1'b1, 4'h4, 32'h0);
    rd(4'h4, va, vb);
    check(vb == 32'h1, "R8 key B locked", vb, 1);
    wr(1'b1, 4'h0, 32'h0);
    rd(4'h0, va, vb);
    check(vb[1] == 1'b1, "R8 key A locked", vb, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule